// File: doc/BRIEF.md
# Atomic AND-on-write peripheral bridge

This bridge sits on an AHB-Lite path between one bus master and one peripheral slave port. A write aimed at a reserved alias window of the address map is not forwarded as a write. It is a command to clear bits at a real peripheral location without risk of interruption. The bridge reads that location, combines the old value with the master's write operand by bitwise AND, and writes the result back. The master sees one write transfer whose data phase is held until the write-back finishes.

Every other transfer goes straight through. This covers reads, including reads of the alias window, and writes outside the command encoding. Such transfers are not delayed, so software can mix ordinary register accesses with atomic bit clears and the ordinary accesses cost no extra time. Byte, halfword and word operands are supported. The master places narrow write data on every byte lane, so the bridge combines only the lanes that the address and size select.

Top module: `rmw_and_bridge`

## Requirements
- R1: After reset, with the master idle, master `m_hready` is high and the slave side shows IDLE (`s_htrans` = 2'b00).
- R2: A write transfer (`m_htrans` NONSEQ 2'b10 or SEQ 2'b11, `m_hwrite` = 1) is an AND command when address bits [31:29] = 3'b010 and bits [28:26] = 3'b001. Bits [25:20] do not affect the command or its target. Any other value in bits [28:26] makes it a plain write.
- R3: The slave address used by the command is the master address with bits [28:20] cleared (mask 0xE00FFFFF), which leaves a 20-bit offset in the 0x4000_0000 peripheral window.
- R4: For a command, the slave first sees a read address phase (`s_hwrite` = 0) in the cycle the master's write is accepted. It then sees a write address phase to the same address with the same size and protection, and no other transfer comes between them.
- R5: `hsize` 0 = byte, 1 = halfword, 2 = word. A byte uses lane `haddr[1:0]` and a halfword uses lanes 2*`haddr[1]` and 2*`haddr[1]`+1. After the command, each selected byte holds the old byte AND the operand byte on that lane, and every other byte is unchanged.
- R6: With a zero-wait slave, the master's command data phase is held low for exactly 2 cycles. The write-back data comes from a register and is held steady while the slave stalls.
- R7: Each cycle in which the slave holds `s_hready` low also holds master `m_hready` low. During a command, the master stalls for 2 cycles plus every slave wait state of the read and the write-back.
- R8: Reads, including reads of the alias window, and non-command writes reach the slave with unchanged address, direction and data. A zero-wait read finishes in its first data-phase cycle.
- R9: A master address phase presented during the command's last data-phase cycle is passed to the slave in that cycle, so the following transfer completes with no added stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_haddr | input | 32 | Master address |
| m_htrans | input | 2 | Master transfer type |
| m_hwrite | input | 1 | Master direction, 1 = write |
| m_hsize | input | 3 | Master transfer size |
| m_hprot | input | 4 | Master protection attributes |
| m_hwdata | input | 32 | Master write data |
| m_hready | output | 1 | Transfer-done indication to the master |
| m_hrdata | output | 32 | Read data to the master |
| s_haddr | output | 32 | Slave address |
| s_htrans | output | 2 | Slave transfer type |
| s_hwrite | output | 1 | Slave direction |
| s_hsize | output | 3 | Slave transfer size |
| s_hprot | output | 4 | Slave protection attributes |
| s_hwdata | output | 32 | Slave write data |
| s_hready | input | 1 | Slave transfer-done indication |
| s_hrdata | input | 32 | Slave read data |

## Verification
A forwarded transfer is due in its first data-phase cycle. The bench checks this by counting the falling edges at which `m_hready` is low before it samples read data. A command's memory result is due once its master data phase ends, which is 2 stalled cycles plus the slave's wait states. The bench model counts every wait state it inserts, so it can predict that stall count exactly. It then reads the location back with a plain read and compares the value with a bench function. Slave-side address order and attributes come from a log kept by the slave model at each accepted address phase. The test of R9 places the next read address phase in the write-back cycle itself.

// File: rtl/rmw_and_pkg.sv
package rmw_and_pkg;

   localparam logic [1:0] HT_IDLE   = 2'b00;
   localparam logic [1:0] HT_NONSEQ = 2'b10;

   typedef enum logic [1:0] {
      ST_PASS,   // forwarding master transfers
      ST_RD,     // slave read data phase, master held
      ST_WA,     // write-back address phase, master held
      ST_WD      // write-back data phase, next address forwarded
   } rmw_state_e;

endpackage

// File: rtl/rmw_and_decode.sv
module rmw_and_decode #(
   parameter int         ADDR_W      = 32,
   parameter int         OFFSET_W    = 20,
   parameter logic [2:0] REGION_CODE = 3'b010,
   parameter logic [2:0] AND_CODE    = 3'b001
) (
   input  logic [ADDR_W-1:0] haddr_i,
   input  logic [1:0]        htrans_i,
   input  logic              hwrite_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] target_o
);
   localparam logic [ADDR_W-1:0] KEEP_MASK =
      {3'b111, {(ADDR_W-3){1'b0}}} | ((ADDR_W'(1) << OFFSET_W) - ADDR_W'(1));

   if (OFFSET_W > ADDR_W - 6) begin : g_bad_offset
      $error("rmw_and_decode: offset field overlaps the command field");
   end

   logic region_match;
   logic code_match;

   assign region_match = (haddr_i[ADDR_W-1 -: 3] == REGION_CODE);
   assign code_match   = (haddr_i[ADDR_W-4 -: 3] == AND_CODE);
   assign hit_o        = htrans_i[1] & hwrite_i & region_match & code_match;
   assign target_o     = haddr_i & KEEP_MASK;

endmodule

// File: rtl/rmw_and_lanes.sv
module rmw_and_lanes #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LW    = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [LW-1:0]     lane_i,
   input  logic [2:0]        size_i,
   output logic [DATA_W-1:0] res_o
);
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("rmw_and_lanes: data width must be whole bytes, at least 16");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic sel;
      assign sel = ((LW'(g) >> size_i) == (lane_i >> size_i));
      assign res_o[g*8 +: 8] = sel ? (old_i[g*8 +: 8] & opnd_i[g*8 +: 8])
                                   : old_i[g*8 +: 8];
   end

endmodule

// File: rtl/rmw_and_bridge.sv
module rmw_and_bridge
   import rmw_and_pkg::*;
#(
   parameter int         ADDR_W      = 32,
   parameter int         DATA_W      = 32,
   parameter int         OFFSET_W    = 20,
   parameter logic [2:0] REGION_CODE = 3'b010,
   parameter logic [2:0] AND_CODE    = 3'b001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] m_haddr,
   input  logic [1:0]        m_htrans,
   input  logic              m_hwrite,
   input  logic [2:0]        m_hsize,
   input  logic [3:0]        m_hprot,
   input  logic [DATA_W-1:0] m_hwdata,
   output logic              m_hready,
   output logic [DATA_W-1:0] m_hrdata,
   output logic [ADDR_W-1:0] s_haddr,
   output logic [1:0]        s_htrans,
   output logic              s_hwrite,
   output logic [2:0]        s_hsize,
   output logic [3:0]        s_hprot,
   output logic [DATA_W-1:0] s_hwdata,
   input  logic              s_hready,
   input  logic [DATA_W-1:0] s_hrdata
);
   localparam int         LW     = $clog2(DATA_W / 8);
   localparam logic [2:0] SZ_MAX = 3'(LW);

   if (ADDR_W < 32) begin : g_bad_addr
      $error("rmw_and_bridge: address width below 32");
   end

   rmw_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [2:0]        size_q;
   logic [3:0]        prot_q;
   logic [DATA_W-1:0] wd_q;

   logic              hit;
   logic [ADDR_W-1:0] target;
   logic [DATA_W-1:0] merged;
   logic              fwd;
   logic              cmd_accept;

   rmw_and_decode #(
      .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W),
      .REGION_CODE(REGION_CODE), .AND_CODE(AND_CODE)
   ) u_decode (
      .haddr_i(m_haddr), .htrans_i(m_htrans), .hwrite_i(m_hwrite),
      .hit_o(hit), .target_o(target)
   );

   rmw_and_lanes #(.DATA_W(DATA_W)) u_lanes (
      .old_i(s_hrdata), .opnd_i(m_hwdata), .lane_i(addr_q[LW-1:0]),
      .size_i(size_q), .res_o(merged)
   );

   assign fwd        = (st_q == ST_PASS) || (st_q == ST_WD);
   assign cmd_accept = fwd && s_hready && hit;

   // master-facing data phase
   always_comb begin
      m_hready = fwd ? s_hready : 1'b0;
      m_hrdata = s_hrdata;
      s_hwdata = (st_q == ST_WD) ? wd_q : m_hwdata;
   end

   // slave-facing address phase
   always_comb begin
      s_haddr  = addr_q;
      s_hsize  = size_q;
      s_hprot  = prot_q;
      s_hwrite = 1'b0;
      s_htrans = HT_IDLE;
      case (st_q)
         ST_RD: s_htrans = HT_IDLE;
         ST_WA: begin
            s_htrans = HT_NONSEQ;
            s_hwrite = 1'b1;
         end
         default: begin
            s_htrans = m_htrans;
            s_hsize  = m_hsize;
            s_hprot  = m_hprot;
            s_haddr  = hit ? target : m_haddr;
            s_hwrite = hit ? 1'b0 : m_hwrite;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_PASS;
         addr_q <= '0;
         size_q <= '0;
         prot_q <= '0;
         wd_q   <= '0;
      end else begin
         case (st_q)
            ST_PASS, ST_WD: begin
               if (s_hready) begin
                  if (hit) begin
                     addr_q <= target;
                     size_q <= m_hsize;
                     prot_q <= m_hprot;
                     st_q   <= ST_RD;
                  end else begin
                     st_q   <= ST_PASS;
                  end
               end
            end
            ST_RD: begin
               if (s_hready) begin
                  wd_q <= merged;
                  st_q <= ST_WA;
               end
            end
            ST_WA: begin
               if (s_hready) st_q <= ST_WD;
            end
            default: st_q <= ST_PASS;
         endcase
      end
   end

   // R6: an accepted command always holds the master in the next cycle
   p_stall_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept |=> !m_hready);

   // R4: nothing else is issued to the slave while the read is outstanding
   p_quiet_during_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept |=> (s_htrans == HT_IDLE));

   // R7: a slave wait state always reaches the master
   p_wait_reaches_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !s_hready |-> !m_hready);

   // R6: write-back data stays steady across slave wait states
   p_wb_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WD && !s_hready) |=> $stable(s_hwdata));

   // R5: command sizes stay within the data bus
   p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept |-> (m_hsize <= SZ_MAX));

endmodule

// File: tb/rmw_and_bridge_test.sv
`timescale 1ns/100ps
module rmw_and_bridge_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] m_haddr = '0;
   logic [1:0]  m_htrans = '0;
   logic        m_hwrite = 1'b0;
   logic [2:0]  m_hsize = '0;
   logic [3:0]  m_hprot = '0;
   logic [31:0] m_hwdata = '0;
   logic        m_hready;
   logic [31:0] m_hrdata;
   logic [31:0] s_haddr;
   logic [1:0]  s_htrans;
   logic        s_hwrite;
   logic [2:0]  s_hsize;
   logic [3:0]  s_hprot;
   logic [31:0] s_hwdata;
   logic        s_hready;
   logic [31:0] s_hrdata;

   always #2.5 clk = ~clk;

   rmw_and_bridge uut (.*);

   int n_chk = 0;
   int n_fail = 0;

   // ---------------- behavioural peripheral with wait states
   logic [31:0] mem [0:255];
   logic        sl_pend, sl_wr;
   logic [31:0] sl_addr;
   logic [2:0]  sl_size;
   int          sl_wait;
   bit          waits_on = 1'b0;
   int          ev_cnt = 0, ws_cnt = 0;
   int          rd_ev = 0, wr_ev = 0;
   logic [31:0] rd_addr_log = '0, wr_addr_log = '0;
   logic [3:0]  rd_prot_log = '0, wr_prot_log = '0;
   logic [2:0]  rd_size_log = '0, wr_size_log = '0;

   function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] nw,
                                              input logic [31:0] a, input logic [2:0] sz,
                                              input bit do_and);
      logic [31:0] r = old;
      for (int i = 0; i < 4; i++) begin
         if ((i >> sz) == (int'(a[1:0]) >> sz))
            r[i*8 +: 8] = do_and ? (old[i*8 +: 8] & nw[i*8 +: 8]) : nw[i*8 +: 8];
      end
      return r;
   endfunction

   function automatic logic [31:0] replicate(input logic [31:0] d, input logic [2:0] sz);
      if (sz == 3'd0) return {4{d[7:0]}};
      if (sz == 3'd1) return {2{d[15:0]}};
      return d;
   endfunction

   assign s_hready = !sl_pend || (sl_wait == 0);
   assign s_hrdata = (sl_pend && !sl_wr) ? mem[sl_addr[9:2]] : 32'h0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sl_pend <= 1'b0;
         sl_wr   <= 1'b0;
         sl_wait <= 0;
         sl_addr <= '0;
         sl_size <= '0;
      end else if (sl_pend && sl_wait != 0) begin
         sl_wait <= sl_wait - 1;
         ws_cnt  <= ws_cnt + 1;
      end else begin
         if (sl_pend && sl_wr)
            mem[sl_addr[9:2]] <= lane_merge(mem[sl_addr[9:2]], s_hwdata, sl_addr, sl_size, 1'b0);
         sl_pend <= s_htrans[1];
         if (s_htrans[1]) begin
            sl_addr <= s_haddr;
            sl_size <= s_hsize;
            sl_wr   <= s_hwrite;
            sl_wait <= waits_on ? int'($urandom_range(0, 2)) : 0;
            ev_cnt  <= ev_cnt + 1;
            if (s_hwrite) begin
               wr_ev <= ev_cnt; wr_addr_log <= s_haddr;
               wr_prot_log <= s_hprot; wr_size_log <= s_hsize;
            end else begin
               rd_ev <= ev_cnt; rd_addr_log <= s_haddr;
               rd_prot_log <= s_hprot; rd_size_log <= s_hsize;
            end
         end
      end
   end

   // ---------------- checking and bus tasks
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d,
                            input logic [3:0] prot, output int stalls);
      m_haddr = a; m_hsize = sz; m_hwrite = 1'b1; m_htrans = 2'b10; m_hprot = prot;
      while (!m_hready) @(negedge clk);
      @(negedge clk);
      m_htrans = 2'b00; m_hwrite = 1'b0; m_hwdata = replicate(d, sz);
      stalls = 0;
      while (!m_hready) begin stalls++; @(negedge clk); end
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output int stalls);
      m_haddr = a; m_hsize = 3'd2; m_hwrite = 1'b0; m_htrans = 2'b10; m_hprot = 4'h3;
      while (!m_hready) @(negedge clk);
      @(negedge clk);
      m_htrans = 2'b00;
      stalls = 0;
      while (!m_hready) begin stalls++; @(negedge clk); end
      d = m_hrdata;
      @(negedge clk);
   endtask

   // command write whose read follow-up is issued during the last data-phase cycle
   task automatic write_then_read(input logic [31:0] wa, input logic [31:0] d,
                                  input logic [31:0] ra, output logic [31:0] rd,
                                  output int rstalls);
      m_haddr = wa; m_hsize = 3'd2; m_hwrite = 1'b1; m_htrans = 2'b10; m_hprot = 4'h1;
      while (!m_hready) @(negedge clk);
      @(negedge clk);
      m_hwdata = d;
      m_haddr = ra; m_hwrite = 1'b0; m_htrans = 2'b10;
      while (!m_hready) @(negedge clk);
      @(negedge clk);
      m_htrans = 2'b00;
      rstalls = 0;
      while (!m_hready) begin rstalls++; @(negedge clk); end
      rd = m_hrdata;
      @(negedge clk);
   endtask

   function automatic logic [31:0] alias_addr(input logic [31:0] off, input logic [5:0] dc);
      return 32'h4400_0000 | (32'(dc) << 20) | (off & 32'h000F_FFFF);
   endfunction

   task automatic do_and_case(input string req, input logic [31:0] off, input logic [2:0] sz,
                              input logic [31:0] op, input logic [5:0] dc, input bit check_stall);
      logic [31:0] old, now, base;
      logic [3:0]  prot;
      int st, ws0;
      base = 32'h4000_0000 | (off & 32'h3FC);
      prot = 4'($urandom_range(0, 15));
      bus_read(base, old, st);
      ws0 = ws_cnt;
      bus_write(alias_addr(off, dc), sz, op, prot, st);
      if (check_stall) chk({req, " R6 stall"}, 32'(st), 32'd2);
      chk({req, " R7 stall tracks waits"}, 32'(st), 32'(2 + ws_cnt - ws0));
      chk({req, " R3 read target"}, rd_addr_log, 32'h4000_0000 | (off & 32'h000F_FFFF));
      chk({req, " R4 same write target"}, wr_addr_log, rd_addr_log);
      chk({req, " R4 read then write"}, 32'(wr_ev), 32'(rd_ev + 1));
      chk({req, " R4 attrs"}, {24'h0, wr_prot_log, 1'b0, wr_size_log}, {24'h0, prot, 1'b0, sz});
      bus_read(base, now, st);
      chk({req, " R5 result"}, now, lane_merge(old, replicate(op, sz), off, sz, 1'b1));
   endtask

   // ---------------- watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      logic [31:0] d, exp;
      int st;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) mem[i] = $urandom;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 hready after reset", 32'(m_hready), 32'd1);
      chk("R1 slave idle after reset", 32'(s_htrans), 32'd0);

      // plain pass-through, zero wait
      bus_write(32'h4000_0040, 3'd2, 32'hCAFE_1234, 4'h3, st);
      chk("R8 plain write no stall", 32'(st), 32'd0);
      chk("R8 plain write address", wr_addr_log, 32'h4000_0040);
      bus_read(32'h4000_0040, d, st);
      chk("R8 plain read data", d, 32'hCAFE_1234);
      chk("R8 plain read no stall", 32'(st), 32'd0);

      // directed commands, zero wait
      do_and_case("word", 32'h010, 3'd2, 32'hF0F0_0FF0, 6'h00, 1'b1);
      for (int ln = 0; ln < 4; ln++)
         do_and_case("byte lane", 32'h020 + 32'(ln), 3'd0, 32'h0000_005A, 6'h00, 1'b1);
      do_and_case("half low", 32'h030, 3'd1, 32'h0000_3C3C, 6'h00, 1'b1);
      do_and_case("half high", 32'h032, 3'd1, 32'h0000_A5A5, 6'h00, 1'b1);

      // R2: bits [25:20] are ignored
      do_and_case("R2 dont-care bits", 32'h044, 3'd2, 32'h1357_9BDF, 6'h2A, 1'b1);

      // R2: other command code is a plain write to the raw address
      bus_write(32'h4800_0050, 3'd2, 32'h0BAD_F00D, 4'h3, st);
      chk("R2 non-command write address", wr_addr_log, 32'h4800_0050);
      chk("R2 non-command write no stall", 32'(st), 32'd0);
      bus_read(32'h4000_0050, d, st);
      chk("R2 non-command write data", d, 32'h0BAD_F00D);

      // R8: read of alias window passes unchanged
      bus_read(32'h4400_0050, d, st);
      chk("R8 alias read address", rd_addr_log, 32'h4400_0050);
      chk("R8 alias read data", d, 32'h0BAD_F00D);

      // R9: next read forwarded during write-back data phase
      bus_read(32'h4000_0060, exp, st);
      write_then_read(32'h4400_0060, 32'h00FF_FF00, 32'h4000_0060, d, st);
      chk("R9 follow-up read no stall", 32'(st), 32'd0);
      chk("R9 follow-up read sees result", d, exp & 32'h00FF_FF00);

      // constrained random with slave wait states
      waits_on = 1'b1;
      for (int k = 0; k < 40; k++) begin
         logic [2:0]  sz;
         logic [31:0] off;
         sz  = 3'($urandom_range(0, 2));
         off = 32'($urandom_range(0, 1023));
         off = off & ~((32'd1 << sz) - 32'd1);
         do_and_case("random", off, sz, $urandom, 6'($urandom_range(0, 63)), 1'b0);
      end
      waits_on = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule